// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory of 2048 bytes. It watches oversampled clock and data lines from the bus, finds start and stop conditions, checks the device-select byte and then runs the write or read command that follows. For writes it loads an 11-bit word address and passes each received byte to a page buffer through a write strobe. A stop commits the buffered bytes, and a start that arrives before any stop throws them away. For reads it fetches bytes from a synchronous memory port and shifts them out on the bus. The data line is driven through an open-drain pull-down enable.

The select byte holds a fixed four-bit device code, a three-bit block number and a direction bit. The block number gives the top three address bits of a write or a random read. One address counter serves every command. A write steps the counter only inside a 16-byte page. A read steps it across the whole 2048-byte space. Whether a current-address read starts at the counter or one past it depends on whether the last access was a read or a write.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: The engine drives nothing and strobes nothing until it detects a start (data falling while clock is high). A stop (data rising while clock is high) always returns it to idle.
- R2: A select byte whose four upper bits are 1010 is acknowledged by pulling data low during the ninth clock. Any other select byte gets no acknowledge, and the engine then ignores the bus until the next start.
- R3: In write direction (select bit 0 = 0), the word-address byte and every data byte are acknowledged. The loaded address is {select bits 3..1, word-address byte}.
- R4: Data is sampled on rising clock edges. The pull-down enable changes only after a falling clock edge, or on a start or stop, and never while the clock is high.
- R5: Each write data byte gives one strobe with its address. The first byte goes to the loaded address. Each later byte adds one to address bits 3..0 and wraps within the 16-byte page, while bits 10..4 stay fixed.
- R6: A stop after at least one data byte gives one commit pulse. A start before that stop gives one cancel pulse instead, and the array keeps its old contents.
- R7: Read data is sent MSB first. A low master acknowledge makes the engine send the next byte. A high acknowledge makes it release the line and drive nothing until the next start.
- R8: A current-address read (select bit 0 = 1, no word address) ignores the select block bits. After a read it returns the byte one past the last one read. After a write it returns the byte at the last written address.
- R9: A random read (write-direction select, word address, repeated start, read select) returns data starting at the loaded address.
- R10: Sequential reads step the full 11-bit address and wrap from 0x7FF to 0x000.
- R11: A start in the middle of any byte abandons that byte, and the engine expects a select byte next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mem_addr_o | output | 11 | Address for a read fetch or a buffer write |
| mem_rdata_i | input | 8 | Read data, valid one clock after the address |
| mem_wdata_o | output | 8 | Byte for the page buffer |
| mem_we_o | output | 1 | Page-buffer write strobe, one clock |
| mem_commit_o | output | 1 | Pulse: program the buffered bytes into the array |
| mem_cancel_o | output | 1 | Pulse: discard the buffered bytes |

## Verification
Two events can land in the same clock. The first is a start condition, which can arrive while a write is still uncommitted or in the middle of a byte. On that clock the engine must both restart select reception and report a cancel instead of a commit. The bench provokes this with a repeated start after a data byte and with a start after only four bits of a byte. The outcome is judged by the cancel pulse count, the missing commit, and the unchanged array contents read back afterwards. The second overlap is the master's acknowledge sample and the next read fetch, at the boundary where the address wraps from 0x7FF to 0x000. That case is judged byte by byte against the bench's own address model.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_WAIT_STOP
    } twm_state_e;

    typedef enum logic [1:0] {
        K_SEL,
        K_WADDR,
        K_WDATA
    } twm_kind_e;

    typedef enum logic [1:0] {
        AOP_HOLD,
        AOP_LOAD,
        AOP_PAGE,
        AOP_NEXT
    } twm_aop_e;

endpackage

// File: rtl/twm_line_sampler.sv
module twm_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_s, sda_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            assign scl_d[g] = scl_i;
            assign sda_d[g] = sda_i;
        end else begin : g_rest
            assign scl_d[g] = scl_q[g-1];
            assign sda_d[g] = sda_q[g-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= '1;
            sda_q   <= '1;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_q   <= scl_d;
            sda_q   <= sda_d;
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign sda_o   = sda_s;
    assign rise_o  = scl_s & ~scl_p_q;
    assign fall_o  = ~scl_s & scl_p_q;
    assign start_o = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_o  = scl_s & scl_p_q & ~sda_p_q & sda_s;

    // R1
    cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, rise_o, fall_o}));

endmodule

// File: rtl/twm_addr_ctr.sv
module twm_addr_ctr
    import twm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  twm_aop_e          op_i,
    input  logic [ADDR_W-1:0] load_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [PAGE_W-1:0] low_inc;

    assign low_inc = addr_q[PAGE_W-1:0] + 1'b1;

    always_comb begin
        addr_d = addr_q;
        case (op_i)
            AOP_LOAD: addr_d = load_i;
            AOP_PAGE: addr_d = {addr_q[ADDR_W-1:PAGE_W], low_inc};
            AOP_NEXT: addr_d = addr_q + 1'b1;
            default:  addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R5
    page_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == AOP_PAGE) |=> (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])));

    // R10
    seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == AOP_NEXT && addr_o == '1) |=> (addr_o == '0));

endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
    import twm_pkg::*;
#(
    parameter int BLK_W       = 3,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic [BLK_W+7:0] mem_addr_o,
    input  logic [7:0]       mem_rdata_i,
    output logic [7:0]       mem_wdata_o,
    output logic             mem_we_o,
    output logic             mem_commit_o,
    output logic             mem_cancel_o
);
    localparam int ADDR_W = BLK_W + 8;

    typedef struct packed {
        twm_state_e       state;
        twm_kind_e        kind;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic             rw;
        logic             ack_ok;
        logic [BLK_W-1:0] blk;
        logic             wr_first;
        logic             rd_adv;
        logic             wr_pend;
        logic             oe;
        logic             we;
        logic [7:0]       wdata;
        logic             commit;
        logic             cancel;
    } eng_t;

    eng_t n, q;

    logic              sda_s, rise_e, fall_e, start_e, stop_e;
    logic [7:0]        rx_byte;
    twm_aop_e          aop;
    logic [ADDR_W-1:0] aload;

    twm_line_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_o   (sda_s),
        .rise_o  (rise_e),
        .fall_o  (fall_e),
        .start_o (start_e),
        .stop_o  (stop_e)
    );

    twm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (aop),
        .load_i (aload),
        .addr_o (mem_addr_o)
    );

    assign rx_byte = {q.sh[6:0], sda_s};

    always_comb begin
        n        = q;
        n.we     = 1'b0;
        n.commit = 1'b0;
        n.cancel = 1'b0;
        aop      = AOP_HOLD;
        aload    = '0;
        if (start_e) begin
            n.state   = ST_RX;
            n.kind    = K_SEL;
            n.cnt     = '0;
            n.oe      = 1'b0;
            n.cancel  = q.wr_pend;
            n.wr_pend = 1'b0;
        end else if (stop_e) begin
            n.state   = ST_IDLE;
            n.oe      = 1'b0;
            n.commit  = q.wr_pend;
            n.wr_pend = 1'b0;
        end else begin
            case (q.state)
                ST_RX: if (rise_e) begin
                    n.sh  = rx_byte;
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == 4'd7) begin
                        n.state = ST_RX_END;
                        case (q.kind)
                            K_SEL: begin
                                n.ack_ok = (rx_byte[7:4] == DEV_CODE);
                                n.rw     = rx_byte[0];
                                if (rx_byte[7:4] == DEV_CODE) begin
                                    if (rx_byte[0]) begin
                                        aop      = q.rd_adv ? AOP_NEXT : AOP_HOLD;
                                        n.rd_adv = 1'b1;
                                    end else begin
                                        n.blk = rx_byte[BLK_W:1];
                                    end
                                end
                            end
                            K_WADDR: begin
                                n.ack_ok   = 1'b1;
                                aop        = AOP_LOAD;
                                aload      = {q.blk, rx_byte};
                                n.wr_first = 1'b1;
                                n.rd_adv   = 1'b0;
                            end
                            default: begin
                                n.ack_ok   = 1'b1;
                                aop        = q.wr_first ? AOP_HOLD : AOP_PAGE;
                                n.wr_first = 1'b0;
                                n.we       = 1'b1;
                                n.wdata    = rx_byte;
                                n.wr_pend  = 1'b1;
                                n.rd_adv   = 1'b0;
                            end
                        endcase
                    end
                end
                ST_RX_END: if (fall_e) begin
                    n.state = q.ack_ok ? ST_ACK : ST_IDLE;
                    n.oe    = q.ack_ok;
                end
                ST_ACK: if (fall_e) begin
                    n.cnt = '0;
                    n.oe  = 1'b0;
                    if (q.kind == K_SEL && q.rw) begin
                        n.state = ST_TX;
                        n.sh    = mem_rdata_i;
                        n.oe    = ~mem_rdata_i[7];
                    end else begin
                        n.state = ST_RX;
                        n.kind  = (q.kind == K_SEL) ? K_WADDR : K_WDATA;
                    end
                end
                ST_TX: begin
                    if (rise_e) n.cnt = q.cnt + 1'b1;
                    if (fall_e) begin
                        if (q.cnt == 4'd8) begin
                            n.oe    = 1'b0;
                            n.state = ST_TX_ACK;
                        end else begin
                            n.sh = {q.sh[6:0], 1'b0};
                            n.oe = ~q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: if (rise_e) begin
                    if (!sda_s) begin
                        aop     = AOP_NEXT;
                        n.state = ST_TX_NEXT;
                    end else begin
                        n.state = ST_WAIT_STOP;
                    end
                end
                ST_TX_NEXT: if (fall_e) begin
                    n.sh    = mem_rdata_i;
                    n.oe    = ~mem_rdata_i[7];
                    n.cnt   = '0;
                    n.state = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.kind  <= K_SEL;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o     = q.oe;
    assign mem_wdata_o  = q.wdata;
    assign mem_we_o     = q.we;
    assign mem_commit_o = q.commit;
    assign mem_cancel_o = q.cancel;

    // R4
    oe_edge_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> $past(fall_e || start_e || stop_e));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && !start_e) |=> (q.state == ST_IDLE && !q.oe && !q.we));

    // R6
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> $past(stop_e));

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.we, q.commit, q.cancel}));

    // R7
    wait_stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT_STOP) |-> !q.oe);

endmodule

// File: tb/test_twowire_eeprom_slave.sv
module test_twowire_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 8;
    localparam int MEMSZ = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [10:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00;
    logic [7:0] mem_wdata;
    logic mem_we, mem_commit, mem_cancel;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    twowire_eeprom_slave i_twowire_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
        .mem_commit_o(mem_commit), .mem_cancel_o(mem_cancel)
    );

    int errors = 0;
    int checks = 0;
    int ncommit = 0;
    int ncancel = 0;
    int qviol = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] bmem [0:MEMSZ-1];
    logic [7:0] exp_mem [0:MEMSZ-1];
    logic [18:0] pend [$];
    logic [18:0] exp_wr [$];
    int ptr = 0;
    bit adv = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // array plus page buffer seen by the engine
    always @(posedge clk) begin
        mem_rdata <= bmem[mem_addr];
        if (mem_we) pend.push_back({mem_addr, mem_wdata});
        if (mem_commit) begin
            foreach (pend[k]) bmem[pend[k][18:8]] = pend[k][7:0];
            pend.delete();
            ncommit++;
        end
        if (mem_cancel) begin
            pend.delete();
            ncancel++;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_m && (sda_oe !== prev_oe)) begin
                errors++;
                $display("FAIL R4 pull-down moved while clock high: actual=%0b expected=%0b",
                         sda_oe, prev_oe);
            end
            if (quiet && (sda_oe || mem_we || mem_commit || mem_cancel)) qviol++;
            if (mem_we) begin
                if (exp_wr.size() == 0)
                    chk(1'b0, "R5", "unexpected write strobe", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [18:0] e;
                    e = exp_wr.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R5", "strobe addr/data",
                        {mem_addr, mem_wdata}, e);
                end
            end
        end
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QW);
        scl_m = 1'b1; tick(QW);
        sda_m = 1'b0; tick(QW);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(QW); sda_m = 1'b0; tick(QW);
        scl_m = 1'b1; tick(QW);
        sda_m = 1'b1; tick(QW);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            tick(QW); sda_m = b[i]; tick(QW);
            scl_m = 1'b1; tick(2*QW);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        tick(QW); sda_m = 1'b1; tick(QW);
        scl_m = 1'b1; tick(QW);
        ack = sda_line; tick(QW);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2*QW); scl_m = 1'b1; tick(QW);
            b[i] = sda_line; tick(QW);
            scl_m = 1'b0;
        end
        tick(QW); sda_m = nack; tick(QW);
        scl_m = 1'b1; tick(2*QW);
        scl_m = 1'b0; tick(QW);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] sel(input int blk, input bit rd);
        return {4'b1010, 3'(blk), rd};
    endfunction

    task automatic write_seq(input int a, input int n, input int seed);
        logic ack;
        int wa;
        logic [7:0] d;
        int c0;
        c0 = ncommit;
        bus_start();
        send_byte(sel(a >> 8, 1'b0), ack);
        chk(ack == 1'b0, "R2", "write select ack", ack, 0);
        send_byte(8'(a), ack);
        chk(ack == 1'b0, "R3", "word address ack", ack, 0);
        for (int i = 0; i < n; i++) begin
            wa = (i == 0) ? a : ((a & 'h7F0) | ((a + i) & 'hF));
            d = 8'((seed + 13 * i) & 'hFF);
            exp_wr.push_back({11'(wa), d});
            send_byte(d, ack);
            chk(ack == 1'b0, "R3", "data ack", ack, 0);
            exp_mem[wa] = d;
            ptr = wa;
        end
        adv = 1'b0;
        bus_stop();
        tick(4);
        chk(ncommit == c0 + 1, "R6", "commit pulses after stop", ncommit - c0, 1);
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            ptr = adv ? ((ptr + 1) % MEMSZ) : ptr;
            adv = 1'b1;
            recv_byte(i == n - 1, b);
            chk(b == exp_mem[ptr], req, $sformatf("read byte at 0x%0h", ptr), b, exp_mem[ptr]);
        end
    endtask

    task automatic read_current(input int n, input int blk, input string req);
        logic ack;
        bus_start();
        send_byte(sel(blk, 1'b1), ack);
        chk(ack == 1'b0, "R2", "read select ack", ack, 0);
        read_body(n, req);
        bus_stop();
    endtask

    task automatic read_random(input int a, input int n, input string req);
        logic ack;
        bus_start();
        send_byte(sel(a >> 8, 1'b0), ack);
        chk(ack == 1'b0, "R9", "dummy-write select ack", ack, 0);
        send_byte(8'(a), ack);
        chk(ack == 1'b0, "R9", "word address ack", ack, 0);
        ptr = a; adv = 1'b0;
        bus_start();
        send_byte(sel(a >> 8, 1'b1), ack);
        chk(ack == 1'b0, "R9", "read select ack", ack, 0);
        read_body(n, req);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        logic [7:0] b;
        int c0, k0;
        for (int i = 0; i < MEMSZ; i++) begin
            bmem[i] = 8'((i * 37 + (i >> 8)) & 'hFF);
            exp_mem[i] = bmem[i];
        end
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk({sda_oe, mem_we, mem_commit, mem_cancel} == 4'b0, "R1", "reset outputs",
            {sda_oe, mem_we, mem_commit, mem_cancel}, 0);

        // R1: a full byte clocked out with no start is ignored
        quiet = 1'b1; qviol = 0;
        scl_m = 1'b0;
        send_byte(8'hA0, ack);
        chk(ack == 1'b1, "R1", "no ack before any start", ack, 1);
        bus_stop();
        quiet = 1'b0;
        chk(qviol == 0, "R1", "activity before start", qviol, 0);

        // R3 R5 R6 byte write, then R8 current read after write
        write_seq('h123, 1, 'h5A);
        read_current(1, 6, "R8");
        read_current(2, 0, "R8");
        read_random('h123, 3, "R9");

        // R5 page wrap inside 16 bytes
        write_seq('h2FC, 6, 'h11);
        read_random('h2F0, 16, "R5");
        write_seq('h450, 18, 'h80);
        read_random('h450, 16, "R5");

        // R10 wrap of the full address
        read_random('h7FE, 4, "R10");

        // R2 mismatching select ignored
        quiet = 1'b1; qviol = 0;
        bus_start();
        send_byte(8'hB0, ack);
        chk(ack == 1'b1, "R2", "mismatch select nack", ack, 1);
        send_byte(8'h00, ack);
        chk(ack == 1'b1, "R2", "bytes after mismatch ignored", ack, 1);
        bus_stop();
        quiet = 1'b0;
        chk(qviol == 0, "R2", "activity after mismatch", qviol, 0);

        // R6 R11 repeated start before stop discards the write
        c0 = ncommit; k0 = ncancel;
        bus_start();
        send_byte(sel(3, 1'b0), ack);
        send_byte(8'h40, ack);
        exp_wr.push_back({11'h340, 8'hC3});
        send_byte(8'hC3, ack);
        ptr = 'h340; adv = 1'b0;
        bus_start();
        tick(4);
        chk(ncancel == k0 + 1, "R6", "cancel on early start", ncancel - k0, 1);
        send_byte(sel(0, 1'b1), ack);
        chk(ack == 1'b0, "R11", "select after repeated start", ack, 0);
        read_body(1, "R6");
        bus_stop();
        chk(ncommit == c0, "R6", "no commit after cancel", ncommit - c0, 0);

        // R11 start after half a byte
        bus_start();
        send_bits(8'hA1, 4);
        bus_start();
        send_byte(sel(5, 1'b1), ack);
        chk(ack == 1'b0, "R11", "select after mid-byte start", ack, 0);
        read_body(1, "R11");
        bus_stop();

        // R7 master ack continues, nack silences the engine
        bus_start();
        send_byte(sel(0, 1'b1), ack);
        read_body(2, "R7");
        recv_byte(1'b1, b);
        chk(b == 8'hFF, "R7", "line released after nack", b, 8'hFF);
        bus_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule